// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Sequencer

This block scans a small display memory and drives a multiplexed liquid-crystal panel with up to sixteen common lines and sixty segment lines. Each output is a level-select code. An external resistor ladder turns the code into one of the 1/4-bias voltages. The block only sequences the codes. It produces no analog voltage.

Software reaches the block through a narrow register bus with three registers:
- A control register, which holds the duty, the display state and a key-scan enable.
- A memory address register.
- A memory data port.

Timing comes from a single-cycle tick at the 32.768 kHz base rate, synchronous to the bus clock. Each common slot lasts `SLOT_TICKS` ticks. The drive polarity flips at every frame wrap, so each pixel sees zero net DC.

Level codes used on every output: 0 = VDD, 1 = V1, 2 = V2, 3 = V3, 4 = VLCD, 5 = ground (key-scan pulse). Output lane n occupies bits [3n+2:3n].

Control register (bus select 0):
- Bit 0 is the duty: 0 for 1/8, 1 for 1/16.
- Bits 2:1 are the display state: 00 off, 01 blanked, 11 on, and 10 behaves as off.
- Bit 3 is the key-scan enable.

Top module: `lcdScanSeq`

## Requirements
- R1: After reset, the control and address registers read 0 and every common and segment lane carries code 0 (VDD).
- R2: The data port (select 2) writes memory in every display state. A read of the data port returns the byte at the current address (select 1) only when the state field is 00; in any other state it returns 0. Addresses 120 to 127 ignore writes and read 0.
- R3: A control write changes the duty bit only if the state field held 00 before the write. In other states the duty is kept while the state and key-scan bits still update.
- R4: When the display is not off, exactly one active common is selected at a time. Selection advances 0, 1, 2 … every `SLOT_TICKS` ticks and wraps after common 15 (1/16) or common 7 (1/8).
- R5: In 1/8 duty, commons 8 to 15 carry code 0 at all times.
- R6: Drive levels depend on the frame polarity, which starts at 0 and toggles at every wrap back to common 0:

  | Drive | Polarity 0 | Polarity 1 |
  |---|---|---|
  | Selected common | 4 | 0 |
  | Unselected common | 1 | 3 |
  | Segment, pixel on | 0 | 4 |
  | Segment, pixel off | 2 | 2 |

- R7: The pixel for segment s and common c is bit c[2:0] of byte address 2s + c[3]. The even byte covers commons 7..0 and the odd byte covers commons 15..8.
- R8: In the blanked state (01), every segment carries the pixel-off level while the commons keep scanning as in R4 and R6.
- R9: In the off state, every lane carries code 0 and ticks are ignored. Switching on restarts at common 0, polarity 0, slot start.
- R10: With key-scan enabled and the display not off, every lane carries code 5 during the first tick period of each common slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at the 32.768 kHz base rate |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 address, 2 data |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register (combinational) |
| comCode | output | 48 | Common level codes, 3 bits per common |
| segCode | output | 180 | Segment level codes, 3 bits per segment |

## Verification
The scan is run with a randomly filled memory for two full 1/16 frames, so every slot, both polarities and both bytes of each segment are compared lane by lane. A mid-scan memory rewrite shows that writes land while reads stay blocked. The same random image is then shown blanked, which separates the segment path from the common path. It is next scanned with key-scan on, which isolates the slot-start pulse. Finally it is scanned in 1/8 duty after an off period, which shows the restart point, the shorter wrap and the idle upper commons. Directed cases cover the out-of-range addresses and a duty write attempted while the display is on.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int COM_IDX_W = 4;
  localparam int CODE_W    = 3;

  typedef enum logic [CODE_W-1:0] {
    LV_VDD  = 3'd0,
    LV_V1   = 3'd1,
    LV_V2   = 3'd2,
    LV_V3   = 3'd3,
    LV_VLCD = 3'd4,
    LV_GND  = 3'd5
  } lvl_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2
  } regSel_t;

  typedef struct packed {
    logic                 ramWe;
    logic [6:0]           ramAddr;
    logic [7:0]           ramData;
    logic [COM_IDX_W-1:0] comIdx;
    logic                 pol;
    logic                 duty16;
    logic                 active;
    logic                 blank;
    logic                 scanPulse;
  } scanCtl_t;
endpackage

// File: rtl/lcdScanCtrl.sv
module lcdScanCtrl
  import lcd_pkg::*;
#(
  parameter int NCOM       = 16,
  parameter int NSEG       = 60,
  parameter int SLOT_TICKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  logic [7:0] regWrData,
  output scanCtl_t   st,
  output logic [7:0] ctrlByte,
  output logic [6:0] addrByte,
  output logic       rdOpen
);
  localparam int RAMD = NSEG * 2;
  localparam int TW   = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;

  logic [1:0]           dispState;
  logic                 duty16, keyScan, pol;
  logic [6:0]           addrReg;
  logic [TW-1:0]        tickCnt;
  logic [COM_IDX_W-1:0] comIdx, lastCom;
  logic                 active;

  assign active  = dispState[0];
  assign lastCom = duty16 ? COM_IDX_W'(NCOM - 1) : COM_IDX_W'(NCOM / 2 - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispState <= 2'b00;
      duty16    <= 1'b0;
      keyScan   <= 1'b0;
      addrReg   <= '0;
    end else if (regWrEn) begin
      case (regSel)
        SEL_CTRL: begin
          dispState <= regWrData[2:1];
          keyScan   <= regWrData[3];
          if (dispState == 2'b00) duty16 <= regWrData[0];
        end
        SEL_ADDR: addrReg <= regWrData[6:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      comIdx  <= '0;
      pol     <= 1'b0;
    end else if (!active) begin
      tickCnt <= '0;
      comIdx  <= '0;
      pol     <= 1'b0;
    end else if (tick) begin
      if (tickCnt == TW'(SLOT_TICKS - 1)) begin
        tickCnt <= '0;
        if (comIdx == lastCom) begin
          comIdx <= '0;
          pol    <= ~pol;
        end else begin
          comIdx <= comIdx + 1'b1;
        end
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  always_comb begin
    st.ramWe     = regWrEn && (regSel == SEL_DATA) && (int'(addrReg) < RAMD);
    st.ramAddr   = addrReg;
    st.ramData   = regWrData;
    st.comIdx    = comIdx;
    st.pol       = pol;
    st.duty16    = duty16;
    st.active    = active;
    st.blank     = (dispState == 2'b01);
    st.scanPulse = active && keyScan && (tickCnt == '0);
  end

  assign ctrlByte = {4'b0, keyScan, dispState, duty16};
  assign addrByte = {1'b0, addrReg};
  assign rdOpen   = (dispState == 2'b00);

  // R3
  duty_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispState != 2'b00) |=> $stable(duty16));
  // R4
  com_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    comIdx <= lastCom);
  // R6
  pol_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pol) |-> (comIdx == '0));
  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (comIdx == '0 && tickCnt == '0 && !pol));
endmodule

// File: rtl/lcdScanDatapath.sv
module lcdScanDatapath
  import lcd_pkg::*;
#(
  parameter int NCOM = 16,
  parameter int NSEG = 60
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  scanCtl_t               st,
  output logic [7:0]             ramRdData,
  output logic [NCOM*CODE_W-1:0] comCode,
  output logic [NSEG*CODE_W-1:0] segCode
);
  localparam int RAMD = NSEG * 2;

  logic [7:0] ram [RAMD];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RAMD; i++) ram[i] <= '0;
    end else if (st.ramWe) begin
      ram[st.ramAddr] <= st.ramData;
    end
  end

  assign ramRdData = (int'(st.ramAddr) < RAMD) ? ram[st.ramAddr] : 8'h00;

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    always_comb begin
      if (!st.active)                               comCode[c*CODE_W +: CODE_W] = LV_VDD;
      else if (st.scanPulse)                        comCode[c*CODE_W +: CODE_W] = LV_GND;
      else if (!st.duty16 && c >= NCOM / 2)         comCode[c*CODE_W +: CODE_W] = LV_VDD;
      else if (st.comIdx == COM_IDX_W'(c))          comCode[c*CODE_W +: CODE_W] = st.pol ? LV_VDD : LV_VLCD;
      else                                          comCode[c*CODE_W +: CODE_W] = st.pol ? LV_V3 : LV_V1;
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [7:0] rowByte;
    logic       pixOn;
    assign rowByte = st.comIdx[3] ? ram[2*s+1] : ram[2*s];
    assign pixOn   = rowByte[st.comIdx[2:0]] && !st.blank;
    always_comb begin
      if (!st.active)        segCode[s*CODE_W +: CODE_W] = LV_VDD;
      else if (st.scanPulse) segCode[s*CODE_W +: CODE_W] = LV_GND;
      else if (pixOn)        segCode[s*CODE_W +: CODE_W] = st.pol ? LV_VLCD : LV_VDD;
      else                   segCode[s*CODE_W +: CODE_W] = LV_V2;
    end
  end

  // R5
  short_duty_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.duty16 && !st.scanPulse) |-> (comCode[NCOM*CODE_W-1 : (NCOM/2)*CODE_W] == '0));
  // R10
  scan_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.scanPulse |-> (comCode[CODE_W-1:0] == LV_GND && segCode[CODE_W-1:0] == LV_GND));
  // R9
  off_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.active |-> (comCode == '0 && segCode == '0));
endmodule

// File: rtl/lcdScanSeq.sv
module lcdScanSeq
  import lcd_pkg::*;
#(
  parameter int NCOM       = 16,
  parameter int NSEG       = 60,
  parameter int SLOT_TICKS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic                   regWrEn,
  input  logic [1:0]             regSel,
  input  logic [7:0]             regWrData,
  output logic [7:0]             regRdData,
  output logic [NCOM*CODE_W-1:0] comCode,
  output logic [NSEG*CODE_W-1:0] segCode
);
  scanCtl_t   st;
  logic [7:0] ctrlByte, ramRdData;
  logic [6:0] addrByte;
  logic       rdOpen;

  lcdScanCtrl #(.NCOM(NCOM), .NSEG(NSEG), .SLOT_TICKS(SLOT_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .st(st), .ctrlByte(ctrlByte), .addrByte(addrByte),
    .rdOpen(rdOpen)
  );

  lcdScanDatapath #(.NCOM(NCOM), .NSEG(NSEG)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .ramRdData(ramRdData),
    .comCode(comCode), .segCode(segCode)
  );

  always_comb begin
    case (regSel)
      SEL_CTRL: regRdData = ctrlByte;
      SEL_ADDR: regRdData = {1'b0, addrByte[6:0]};
      SEL_DATA: regRdData = rdOpen ? ramRdData : 8'h00;
      default:  regRdData = 8'h00;
    endcase
  end
endmodule

// File: tb/tb_lcdScanSeq.sv
`timescale 1ns/1ps
module tb_lcdScanSeq;
  localparam int NCOM = 16, NSEG = 60, ST = 4, RAMD = 120;

  logic clk = 0, rstN = 0, tick = 0, regWrEn = 0;
  logic [1:0] regSel = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic [NCOM*3-1:0] comCode;
  logic [NSEG*3-1:0] segCode;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] mRam [RAMD];
  int mState = 0, mDuty16 = 0, mKey = 0, mTc = 0, mCi = 0, mPol = 0;

  lcdScanSeq #(.NCOM(NCOM), .NSEG(NSEG), .SLOT_TICKS(ST)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .comCode(comCode), .segCode(segCode)
  );

  always #4 clk = ~clk;

  function automatic bit mActive();
    return mState == 1 || mState == 3;
  endfunction

  function automatic logic [NCOM*3-1:0] expCom();
    logic [NCOM*3-1:0] v;
    for (int c = 0; c < NCOM; c++) begin
      logic [2:0] e;
      if (!mActive()) e = 0;
      else if (mKey != 0 && mTc == 0) e = 5;
      else if (mDuty16 == 0 && c >= 8) e = 0;
      else if (c == mCi) e = mPol ? 3'd0 : 3'd4;
      else e = mPol ? 3'd3 : 3'd1;
      v[c*3 +: 3] = e;
    end
    return v;
  endfunction

  function automatic logic [NSEG*3-1:0] expSeg();
    logic [NSEG*3-1:0] v;
    for (int s = 0; s < NSEG; s++) begin
      logic [2:0] e;
      logic [7:0] b;
      b = mRam[2*s + (mCi / 8)];
      if (!mActive()) e = 0;
      else if (mKey != 0 && mTc == 0) e = 5;
      else if (mState != 1 && b[mCi % 8]) e = mPol ? 3'd4 : 3'd0;
      else e = 2;
      v[s*3 +: 3] = e;
    end
    return v;
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chkOut(input string req);
    logic [NCOM*3-1:0] ec;
    logic [NSEG*3-1:0] es;
    ec = expCom();
    es = expSeg();
    checks++;
    if (comCode !== ec) begin
      errors++;
      $display("FAIL %s com act=%h exp=%h", req, comCode, ec);
    end
    checks++;
    if (segCode !== es) begin
      errors++;
      $display("FAIL %s seg act=%h exp=%h", req, segCode, es);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
    if (sel == 0) begin
      if (mState == 0) mDuty16 = d[0];
      mState = d[2:1];
      mKey = d[3];
      if (!mActive()) begin mTc = 0; mCi = 0; mPol = 0; end
    end
  endtask

  logic [7:0] curAddr = 0;
  task automatic wrRam(input logic [7:0] a, input logic [7:0] d);
    wr(1, a);
    curAddr = a;
    wr(2, d);
    if (a < RAMD) mRam[a] = d;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = regRdData;
  endtask

  task automatic doTick(input string req);
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
    if (mActive()) begin
      if (mTc == ST - 1) begin
        mTc = 0;
        if (mCi == (mDuty16 ? 15 : 7)) begin mCi = 0; mPol ^= 1; end
        else mCi++;
      end else mTc++;
    end
    chkOut(req);
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED));
    for (int i = 0; i < RAMD; i++) mRam[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, r); chk8("R1 ctrl", r, 8'h00);
    rd(1, r); chk8("R1 addr", r, 8'h00);
    chkOut("R1");
    // R2 fill and read back while off
    for (int i = 0; i < RAMD; i++) wrRam(i[7:0], 8'($urandom));
    for (int k = 0; k < 8; k++) begin
      logic [7:0] a;
      a = 8'($urandom % RAMD);
      wr(1, a);
      rd(2, r); chk8("R2 readback", r, mRam[a]);
    end
    wrRam(8'd0, 8'hFF); wrRam(8'd1, 8'h00);
    wrRam(8'd118, 8'h00); wrRam(8'd119, 8'h80);
    wrRam(8'd120, 8'hA5);
    rd(2, r); chk8("R2 addr120", r, 8'h00);
    wrRam(8'd127, 8'h3C);
    rd(2, r); chk8("R2 addr127", r, 8'h00);
    // ticks while off are ignored (R9)
    for (int k = 0; k < 5; k++) doTick("R9 off");
    // enable 1/16
    wr(0, 8'h07);
    rd(0, r); chk8("R3 ctrl", r, 8'h07);
    chkOut("R9 restart");
    wr(1, 8'd5);
    rd(2, r); chk8("R2 blocked", r, 8'h00);
    // R3 duty locked while on
    wr(0, 8'h06);
    rd(0, r); chk8("R3 lock", r, 8'h07);
    // R4 R6 R7 two frames, with a write mid-scan
    for (int k = 0; k < 2 * 16 * ST; k++) begin
      if (k == 40) wrRam(8'd33, ~mRam[33]);
      doTick("R4 R6 R7 scan");
    end
    // R8 blanked
    wr(0, 8'h03);
    chkOut("R8 blank");
    for (int k = 0; k < 40; k++) doTick("R8 blank");
    // R10 key-scan
    wr(0, 8'h0F);
    for (int k = 0; k < 40; k++) doTick("R10 keyscan");
    // R9 off
    wr(0, 8'h00);
    chkOut("R9 off");
    for (int k = 0; k < 3; k++) doTick("R9 off");
    // R5 1/8 duty after duty change in off state
    wr(0, 8'h00);
    wr(0, 8'h06);
    rd(0, r); chk8("R3 duty8", r, 8'h06);
    for (int k = 0; k < 3 * 8 * ST; k++) doTick("R5 duty8");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule